// File: doc/BRIEF.md
# Configurable Debug Test-Port Multiplexer

This block drives a 16-bit debug port on a QPSK satellite receiver. An 8-bit configuration register sets what the port shows. Its three low bits pick one of eight modes:

- Mode 0 turns the pins off.
- Modes 1 to 6 put an internal signal group on the pins.
- Mode 7 turns the pins into inputs. External I/Q samples then feed the demodulator in place of the internal ADC samples.

Each observation mode has its own update strobe, which matches where its data comes from: the symbol strobe, the decoder byte strobe or the ADC sample strobe. The pin value is captured in a register on that strobe, so it stays stable between updates.

The pads are modelled as separate input, output and output-enable signals. The internal signals being observed arrive as plain input ports.

Top module: `dbg_test_port`

## Requirements
- R1: After reset, cfg_q is 0, tp_out is 0, tp_oe is 0, ext_sel is 0, and demod_i and demod_q are 0.
- R2: The mode is cfg bits [2:0]. Bits [7:3] are stored and read back on cfg_q. A write that leaves bits [2:0] unchanged does not change tp_out or tp_oe.
- R3: tp_oe is 1 for modes 1 to 6 and 0 for modes 0 and 7. It takes its new value in the cycle after the write.
- R4: In mode 1, each symbol strobe captures tp_out = {bb_i, bb_q}.
- R5: In mode 2, each symbol strobe captures tp_out = car_phase. In mode 3, each symbol strobe captures tp_out = sym_phase.
- R6: In mode 4, each byte strobe captures tp_out = {rs_byte, dil_byte}. The symbol strobe and the sample strobe do not update tp_out in this mode.
- R7: In mode 5, each symbol strobe captures tp_out = {agc_acc[5:0], sym_ph4[3:0], sym_cnt[1:0], 4'b0}.
- R8: In mode 6, each sample strobe captures tp_out = {2'b0, adc_i[5:0], 2'b0, adc_q[5:0]}.
- R9: Each sample strobe loads demod_i and demod_q. In mode 7 they take tp_in[13:8] and tp_in[5:0], and tp_in[15:14] and tp_in[7:6] are ignored. In every other mode they take adc_i and adc_q. ext_sel is 1 only in mode 7.
- R10: A symbol strobe held high over consecutive clocks captures fresh data on every one of those clocks.
- R11: A write that changes the mode clears tp_out to 0 in the next cycle. tp_out then stays 0 until the first strobe of the new mode's own source. In modes 0 and 7, tp_out stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Stored configuration |
| sym_stb | input | 1 | One clock per symbol |
| byte_stb | input | 1 | One clock per decoder byte |
| smp_stb | input | 1 | One clock per ADC sample |
| bb_i | input | 8 | I baseband filter output |
| bb_q | input | 8 | Q baseband filter output |
| car_phase | input | 16 | Top 16 bits of the carrier phase |
| sym_phase | input | 16 | Top 16 bits of the symbol timing phase |
| rs_byte | input | 8 | Reed-Solomon output byte |
| dil_byte | input | 8 | Deinterleaver output byte |
| agc_acc | input | 6 | Narrowband AGC accumulator |
| sym_ph4 | input | 4 | 4-bit symbol phase |
| sym_cnt | input | 2 | Symbol count |
| adc_i | input | 6 | I ADC sample |
| adc_q | input | 6 | Q ADC sample |
| tp_in | input | 16 | Port pad input |
| tp_out | output | 16 | Port pad output value |
| tp_oe | output | 1 | Port pad output enable |
| demod_i | output | 6 | I sample to the demodulator |
| demod_q | output | 6 | Q sample to the demodulator |
| ext_sel | output | 1 | Demodulator sample source is the pins |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it:
- A configuration write shows on cfg_q, tp_oe and ext_sel, and clears tp_out, after the edge that samples it.
- A strobe's capture shows on tp_out, demod_i and demod_q after the edge that samples the strobe.

The bench changes inputs one time unit after a rising edge. It reads the outputs one time unit after the next rising edge. This way each check falls in the first cycle in which the result is due. No check relies on a value that carries over from a later cycle.

// File: rtl/dbg_test_port.sv
module dbg_test_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_q,
  input  logic        sym_stb,
  input  logic        byte_stb,
  input  logic        smp_stb,
  input  logic [7:0]  bb_i,
  input  logic [7:0]  bb_q,
  input  logic [15:0] car_phase,
  input  logic [15:0] sym_phase,
  input  logic [7:0]  rs_byte,
  input  logic [7:0]  dil_byte,
  input  logic [5:0]  agc_acc,
  input  logic [3:0]  sym_ph4,
  input  logic [1:0]  sym_cnt,
  input  logic [5:0]  adc_i,
  input  logic [5:0]  adc_q,
  input  logic [15:0] tp_in,
  output logic [15:0] tp_out,
  output logic        tp_oe,
  output logic [5:0]  demod_i,
  output logic [5:0]  demod_q,
  output logic        ext_sel
);

  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_BB   = 3'd1;
  localparam logic [2:0] M_CAR  = 3'd2;
  localparam logic [2:0] M_SPH  = 3'd3;
  localparam logic [2:0] M_DEC  = 3'd4;
  localparam logic [2:0] M_PACK = 3'd5;
  localparam logic [2:0] M_ADC  = 3'd6;
  localparam logic [2:0] M_EXT  = 3'd7;

  logic [2:0]  mode;
  logic [15:0] view;
  logic        upd;
  logic        mode_chg;

  assign mode     = cfg_q[2:0];
  assign mode_chg = cfg_we && (cfg_wdata[2:0] != mode);

  always_comb begin
    view = '0;
    upd  = 1'b0;
    case (mode)
      M_BB:   begin view = {bb_i, bb_q};                           upd = sym_stb;  end
      M_CAR:  begin view = car_phase;                              upd = sym_stb;  end
      M_SPH:  begin view = sym_phase;                              upd = sym_stb;  end
      M_DEC:  begin view = {rs_byte, dil_byte};                    upd = byte_stb; end
      M_PACK: begin view = {agc_acc, sym_ph4, sym_cnt, 4'b0000};   upd = sym_stb;  end
      M_ADC:  begin view = {2'b00, adc_i, 2'b00, adc_q};           upd = smp_stb;  end
      default: begin view = '0;                                    upd = 1'b0;     end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      tp_out  <= '0;
      tp_oe   <= 1'b0;
      ext_sel <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q   <= cfg_wdata;
        tp_oe   <= (cfg_wdata[2:0] != M_OFF) && (cfg_wdata[2:0] != M_EXT);
        ext_sel <= (cfg_wdata[2:0] == M_EXT);
      end
      if (mode_chg)
        tp_out <= '0;
      else if (upd)
        tp_out <= view;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      demod_i <= '0;
      demod_q <= '0;
    end else if (smp_stb) begin
      demod_i <= ext_sel ? tp_in[13:8] : adc_i;
      demod_q <= ext_sel ? tp_in[5:0]  : adc_q;
    end
  end

  a_r11_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> tp_out == 16'h0000);

  a_r11_idle_modes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF || mode == M_EXT) |-> tp_out == 16'h0000);

  a_r2_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_stb && !byte_stb && !smp_stb && !cfg_we) |=> $stable(tp_out));

  a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[2:0] == M_OFF || cfg_wdata[2:0] == M_EXT)) |=> !tp_oe);

  a_r4_bb_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BB && sym_stb && !cfg_we) |=> tp_out == {$past(bb_i), $past(bb_q)});

  a_r9_ext_path: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && ext_sel) |=> demod_i == $past(tp_in[13:8]) && demod_q == $past(tp_in[5:0]));

  a_r9_adc_path: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !ext_sel) |=> demod_i == $past(adc_i) && demod_q == $past(adc_q));

endmodule

// File: tb/tb_dbg_test_port.sv
module tb_dbg_test_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_q;
  logic        sym_stb = 1'b0, byte_stb = 1'b0, smp_stb = 1'b0;
  logic [7:0]  bb_i = 8'hA5, bb_q = 8'h3C;
  logic [15:0] car_phase = 16'h1234, sym_phase = 16'hBEEF;
  logic [7:0]  rs_byte = 8'h77, dil_byte = 8'h81;
  logic [5:0]  agc_acc = 6'h2D;
  logic [3:0]  sym_ph4 = 4'h9;
  logic [1:0]  sym_cnt = 2'h2;
  logic [5:0]  adc_i = 6'h15, adc_q = 6'h2A;
  logic [15:0] tp_in = '0;
  logic [15:0] tp_out;
  logic        tp_oe;
  logic [5:0]  demod_i, demod_q;
  logic        ext_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_test_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .sym_stb(sym_stb), .byte_stb(byte_stb), .smp_stb(smp_stb),
    .bb_i(bb_i), .bb_q(bb_q), .car_phase(car_phase), .sym_phase(sym_phase),
    .rs_byte(rs_byte), .dil_byte(dil_byte), .agc_acc(agc_acc), .sym_ph4(sym_ph4),
    .sym_cnt(sym_cnt), .adc_i(adc_i), .adc_q(adc_q), .tp_in(tp_in),
    .tp_out(tp_out), .tp_oe(tp_oe), .demod_i(demod_i), .demod_q(demod_q), .ext_sel(ext_sel)
  );

  // {mode[2:0], strobe[2:0] = {sym,byte,smp}, expected tp_out[15:0], expected oe}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {3'd1, 3'b100, 16'hA53C, 1'b1},
    {3'd2, 3'b100, 16'h1234, 1'b1},
    {3'd3, 3'b100, 16'hBEEF, 1'b1},
    {3'd4, 3'b010, 16'h7781, 1'b1},
    {3'd5, 3'b100, 16'hB660, 1'b1},
    {3'd6, 3'b001, 16'h152A, 1'b1},
    {3'd4, 3'b101, 16'h0000, 1'b1},
    {3'd1, 3'b011, 16'h0000, 1'b1},
    {3'd6, 3'b110, 16'h0000, 1'b1},
    {3'd0, 3'b111, 16'h0000, 1'b0},
    {3'd2, 3'b011, 16'h0000, 1'b1},
    {3'd7, 3'b111, 16'h0000, 1'b0}
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    cyc();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R1 cfg_q", 32'(cfg_q), 0);
    chk("R1 tp_out", 32'(tp_out), 0);
    chk("R1 tp_oe", 32'(tp_oe), 0);
    chk("R1 demod", 32'({demod_i, demod_q, ext_sel}), 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 after release", 32'({tp_out, tp_oe}), 0);

    // Table: R4 R5 R6 R7 R8 R11 R3
    for (int k = 0; k < NV; k++) begin
      wr({5'b0, VEC[k][22:20]});
      chk("R11 cleared after mode change", 32'(tp_out), 0);
      chk("R3 oe", 32'(tp_oe), 32'(VEC[k][0]));
      sym_stb  = VEC[k][19];
      byte_stb = VEC[k][18];
      smp_stb  = VEC[k][17];
      cyc();
      sym_stb = 1'b0; byte_stb = 1'b0; smp_stb = 1'b0;
      chk($sformatf("R4-view mode %0d (R5 R6 R7 R8 R11)", VEC[k][22:20]),
          32'(tp_out), 32'(VEC[k][16:1]));
    end

    // R9: mode 7 injects pins, unused pins ignored
    tp_in = 16'hEBD1;
    smp_stb = 1'b1;
    cyc();
    smp_stb = 1'b0;
    chk("R9 ext_sel", 32'(ext_sel), 1);
    chk("R9 demod from pins", 32'({demod_i, demod_q}), 32'({6'h2B, 6'h11}));
    chk("R11 mode7 output zero", 32'(tp_out), 0);

    // R9: back to ADC path, pins ignored
    wr(8'h06);
    tp_in = 16'h0F0F;
    smp_stb = 1'b1;
    cyc();
    smp_stb = 1'b0;
    chk("R9 ext_sel off", 32'(ext_sel), 0);
    chk("R9 demod from adc", 32'({demod_i, demod_q}), 32'({6'h15, 6'h2A}));
    chk("R8 adc view", 32'(tp_out), 32'h152A);

    // R10: symbol strobe held high
    wr(8'h01);
    sym_stb = 1'b1;
    bb_i = 8'h11; bb_q = 8'h22;
    cyc();
    chk("R10 first high clock", 32'(tp_out), 32'h1122);
    bb_i = 8'h33; bb_q = 8'h44;
    cyc();
    chk("R10 second high clock", 32'(tp_out), 32'h3344);
    sym_stb = 1'b0;
    bb_i = 8'h55; bb_q = 8'h66;
    cyc();
    chk("R10 holds after strobe low", 32'(tp_out), 32'h3344);

    // R2: same mode, upper bits set
    wr(8'hF9);
    chk("R2 cfg readback", 32'(cfg_q), 32'hF9);
    chk("R2 port unchanged", 32'({tp_out, tp_oe}), 32'({16'h3344, 1'b1}));
    byte_stb = 1'b1;
    smp_stb = 1'b1;
    cyc();
    byte_stb = 1'b0;
    smp_stb = 1'b0;
    chk("R6 foreign strobes ignored in mode 1", 32'(tp_out), 32'h3344);

    // R11: switch to mode 4, symbol strobe must not update
    wr(8'h04);
    sym_stb = 1'b1;
    cyc();
    sym_stb = 1'b0;
    chk("R11 wrong source keeps zero", 32'(tp_out), 0);
    byte_stb = 1'b1;
    cyc();
    byte_stb = 1'b0;
    chk("R6 byte strobe capture", 32'(tp_out), 32'h7781);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule